// File: doc/BRIEF.md
# Program Counter and Call-Stack Sequencer

This block is the control-flow unit of a small microcontroller with 16-bit instruction words. It holds a program counter that counts whole instructions and a 16-bit stack pointer into byte-wide data memory. On each accepted instruction it works out the next program counter. For relative jumps and taken branches that is the current address plus the signed offset plus one. A skip moves the counter forward by two. Anything else moves it forward by one. Every program-counter sum wraps modulo the program memory size.

The sequencer also drives the byte-wide data-memory port for stack traffic. Push stores a register byte and then moves the pointer down. Pop moves the pointer up and returns the byte to the register file through a write-back port. A relative call saves its two-byte return address, low byte first. A return reads the two bytes back, high byte first. Both of these take two cycles, and `busy_o` is raised during the second cycle. Arithmetic, flag generation and instruction fetch sit outside the block. The block takes the Z and V flags as inputs, and reads register bytes through a select/data pair.

Top module: `flowseq_top`

## Requirements
- R1: After reset `pc_o` is 0, `busy_o`, `mem_we_o`, `mem_re_o` and `wb_en_o` are 0, and the stack pointer holds `RAM_TOP` (0x08FF by default), so the first push writes that address.
- R2: An accepted word that is none of the decoded flow instructions, and also PUSH or POP, advances `pc_o` by one modulo 2^PC_W. While `instr_valid_i` is low and the block is not busy, `pc_o` holds.
- R3: RJMP, encoded `1100 kkkk kkkk kkkk` with k a 12-bit two's-complement value, loads `pc_o + k + 1` modulo 2^PC_W.
- R4: BREQ `1111 00kk kkkk k001` and BRVS `1111 00kk kkkk k011` take a 7-bit signed k from bits 9:3. They load `pc_o + k + 1` when Z (for BREQ) or V (for BRVS) is 1, and otherwise `pc_o + 1`. The other flag has no effect.
- R5: SBRC `1111 110r rrrr 0bbb` and SBRS `1111 111r rrrr 0bbb` put r (bits 8:4) on `reg_sel_o` and test bit b of `reg_rdata_i`. When that bit is 0 (SBRC) or 1 (SBRS), `pc_o` advances by two; otherwise it advances by one.
- R6: PUSH `1001 001r rrrr 1111` drives `reg_sel_o = r` and writes `reg_rdata_i` at the current stack pointer in the cycle it is accepted. The pointer then decrements by one.
- R7: POP `1001 000r rrrr 1111` reads address stack pointer + 1 in the accepting cycle, with the memory read data valid in that same cycle. In that cycle it raises `wb_en_o` with `wb_sel_o = r` and `wb_data_o` equal to the byte read, and the pointer increments by one.
- R8: RCALL `1101 kkkk kkkk kkkk` writes the low byte of `pc_o + 1` at SP in the accepting cycle. In the next cycle, with `busy_o` high, it writes the high byte at SP-1. `pc_o` then becomes `pc_o + k + 1` and SP has dropped by two.
- R9: RET `1001 0101 0000 1000` reads the high byte at SP+1 in the accepting cycle. In the next cycle, with `busy_o` high, it reads the low byte at SP+2. `pc_o` then holds the 16-bit address formed from the two bytes, and SP has risen by two.
- R10: During a busy cycle the instruction inputs are ignored: they change neither the memory port nor `pc_o`, and `busy_o` never stays high for two cycles in a row.
- R11: Calls and returns move only the return address: `wb_en_o` stays low in every call and return cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present for execution |
| instr_i | input | 16 | Instruction word at `pc_o` |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Two's-complement overflow flag |
| reg_sel_o | output | 5 | Register index for skip test and push data |
| reg_rdata_i | input | 8 | Byte read from the selected register |
| mem_addr_o | output | 16 | Stack byte address |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_re_o | output | 1 | Stack byte read strobe |
| mem_wdata_o | output | 8 | Stack write byte |
| mem_rdata_i | input | 8 | Stack read byte, valid in the same cycle as the address |
| pc_o | output | PC_W | Program counter, in instructions |
| busy_o | output | 1 | Second cycle of a call or return |
| wb_en_o | output | 1 | Pop write-back strobe |
| wb_sel_o | output | 5 | Pop destination register |
| wb_data_o | output | 8 | Pop write-back byte |

## Verification
The assertions assume that data memory returns the byte for `mem_addr_o` within the same cycle. They also assume that `instr_valid_i` only presents a word meant for the current `pc_o`, and that flags and register data are steady while a word is presented. The stimulus meets these conditions in three ways. Its memory model is combinational. It changes inputs only at the falling edge. It holds a stray instruction word steady through each busy cycle, so the ignore rule is exercised without breaking the input contract. Stack depth in the stimulus stays far below the 256 bytes of the memory model, so address aliasing never shows up as a false failure.

// File: rtl/flowseq_pkg.sv
package flowseq_pkg;

  localparam int SP_W    = 16;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 16;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RJMP,
    OP_RCALL,
    OP_RET,
    OP_BREQ,
    OP_BRVS,
    OP_SBRC,
    OP_SBRS,
    OP_PUSH,
    OP_POP
  } flow_op_e;

  typedef enum logic [1:0] {
    STK_IDLE,
    STK_CALL_HI,
    STK_RET_LO
  } stk_state_e;

  // Sign-extend the long (12-bit) relative field of jumps and calls.
  function automatic logic [15:0] sext_long(input logic [11:0] k);
    return {{4{k[11]}}, k};
  endfunction

  // Sign-extend the short (7-bit) relative field of conditional branches.
  function automatic logic [15:0] sext_short(input logic [6:0] k);
    return {{9{k[6]}}, k};
  endfunction

endpackage

// File: rtl/flowseq_decode.sv
module flowseq_decode
  import flowseq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output flow_op_e           op_o,
  output logic [15:0]        offset_o,
  output logic [4:0]         reg_o,
  output logic [2:0]         bit_o
);

  assign reg_o = instr_i[8:4];
  assign bit_o = instr_i[2:0];

  always_comb begin
    casez (instr_i)
      16'b1100_????_????_????: op_o = OP_RJMP;
      16'b1101_????_????_????: op_o = OP_RCALL;
      16'b1001_0101_0000_1000: op_o = OP_RET;
      16'b1111_00??_????_?001: op_o = OP_BREQ;
      16'b1111_00??_????_?011: op_o = OP_BRVS;
      16'b1111_110?_????_0???: op_o = OP_SBRC;
      16'b1111_111?_????_0???: op_o = OP_SBRS;
      16'b1001_001?_????_1111: op_o = OP_PUSH;
      16'b1001_000?_????_1111: op_o = OP_POP;
      default:                 op_o = OP_NONE;
    endcase
  end

  // Jumps and calls carry 12 offset bits; branches carry 7 in bits 9:3.
  always_comb begin
    if (op_o == OP_RJMP || op_o == OP_RCALL) offset_o = sext_long(instr_i[11:0]);
    else                                     offset_o = sext_short(instr_i[9:3]);
  end

endmodule

// File: rtl/flowseq_stack.sv
module flowseq_stack
  import flowseq_pkg::*;
#(
  parameter logic [SP_W-1:0] RAM_TOP = 16'h08FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic [15:0]       ret_in_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              call_done_o,
  output logic              ret_done_o,
  output logic [15:0]       ret_addr_o
);

  stk_state_e        state_q, state_d;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [BYTE_W-1:0] hold_q, hold_d;

  always_comb begin
    state_d     = state_q;
    sp_d        = sp_q;
    hold_d      = hold_q;
    mem_addr_o  = sp_q;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_wdata_o = '0;
    case (state_q)
      STK_IDLE: begin
        if (push_i) begin
          mem_we_o    = 1'b1;
          mem_wdata_o = push_data_i;
          sp_d        = sp_q - 1'b1;
        end else if (call_i) begin
          mem_we_o    = 1'b1;
          mem_wdata_o = ret_in_i[7:0];
          hold_d      = ret_in_i[15:8];
          sp_d        = sp_q - 1'b1;
          state_d     = STK_CALL_HI;
        end else if (pop_i || ret_i) begin
          mem_addr_o = sp_q + 1'b1;
          mem_re_o   = 1'b1;
          sp_d       = sp_q + 1'b1;
          if (ret_i) begin
            hold_d  = mem_rdata_i;
            state_d = STK_RET_LO;
          end
        end
      end
      STK_CALL_HI: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = hold_q;
        sp_d        = sp_q - 1'b1;
        state_d     = STK_IDLE;
      end
      STK_RET_LO: begin
        mem_addr_o = sp_q + 1'b1;
        mem_re_o   = 1'b1;
        sp_d       = sp_q + 1'b1;
        state_d    = STK_IDLE;
      end
      default: state_d = STK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STK_IDLE;
      sp_q    <= RAM_TOP;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      hold_q  <= hold_d;
    end
  end

  assign busy_o      = (state_q != STK_IDLE);
  assign call_done_o = (state_q == STK_CALL_HI);
  assign ret_done_o  = (state_q == STK_RET_LO);
  assign ret_addr_o  = {hold_q, mem_rdata_i};

  // Each written byte moves the pointer down by exactly one.
  assert_write_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> sp_q == $past(sp_q) - 16'd1);

  // Each read byte moves the pointer up by exactly one.
  assert_read_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> sp_q == $past(sp_q) + 16'd1);

  assert_busy_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);

endmodule

// File: rtl/flowseq_top.sv
module flowseq_top
  import flowseq_pkg::*;
#(
  parameter int              PC_W    = 16,
  parameter logic [SP_W-1:0] RAM_TOP = 16'h08FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               flag_z_i,
  input  logic               flag_v_i,
  output logic [4:0]         reg_sel_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               busy_o,
  output logic               wb_en_o,
  output logic [4:0]         wb_sel_o,
  output logic [BYTE_W-1:0]  wb_data_o
);

  // Offset added to a base address, wrapping at the program memory size.
  function automatic logic [PC_W-1:0] pc_add(input logic [PC_W-1:0] base,
                                             input logic [15:0]     delta);
    return base + delta[PC_W-1:0];
  endfunction

  flow_op_e        op;
  logic [15:0]     offset;
  logic [2:0]      bit_sel;
  logic [PC_W-1:0] pc_q, pc_d, call_tgt_q;
  logic [PC_W-1:0] pc_seq, pc_rel, pc_skip;
  logic [15:0]     ret_word, ret_full;
  logic            accept, branch_taken, skip_taken, tested_bit;
  logic            call_done, ret_done;

  flowseq_decode u_decode (
    .instr_i  (instr_i),
    .op_o     (op),
    .offset_o (offset),
    .reg_o    (reg_sel_o),
    .bit_o    (bit_sel)
  );

  assign accept = instr_valid_i && !busy_o;

  flowseq_stack #(.RAM_TOP(RAM_TOP)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (accept && op == OP_PUSH),
    .pop_i       (accept && op == OP_POP),
    .call_i      (accept && op == OP_RCALL),
    .ret_i       (accept && op == OP_RET),
    .push_data_i (reg_rdata_i),
    .ret_in_i    (ret_word),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .call_done_o (call_done),
    .ret_done_o  (ret_done),
    .ret_addr_o  (ret_full)
  );

  assign pc_seq  = pc_add(pc_q, 16'd1);
  assign pc_skip = pc_add(pc_q, 16'd2);
  assign pc_rel  = pc_add(pc_add(pc_q, offset), 16'd1);

  always_comb begin
    ret_word            = '0;
    ret_word[PC_W-1:0]  = pc_seq;
  end

  assign tested_bit   = reg_rdata_i[bit_sel];
  assign branch_taken = (op == OP_BREQ && flag_z_i) || (op == OP_BRVS && flag_v_i);
  assign skip_taken   = (op == OP_SBRC && !tested_bit) || (op == OP_SBRS && tested_bit);

  always_comb begin
    pc_d = pc_q;
    if (call_done)      pc_d = call_tgt_q;
    else if (ret_done)  pc_d = ret_full[PC_W-1:0];
    else if (accept) begin
      case (op)
        OP_RJMP:           pc_d = pc_rel;
        OP_RCALL, OP_RET:  pc_d = pc_q;
        OP_BREQ, OP_BRVS:  pc_d = branch_taken ? pc_rel : pc_seq;
        OP_SBRC, OP_SBRS:  pc_d = skip_taken ? pc_skip : pc_seq;
        default:           pc_d = pc_seq;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= '0;
      call_tgt_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (accept && op == OP_RCALL) call_tgt_q <= pc_rel;
    end
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = accept && op == OP_POP;
  assign wb_sel_o  = reg_sel_o;
  assign wb_data_o = mem_rdata_i;

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_NONE || op == OP_PUSH || op == OP_POP)
      |=> pc_q == $past(pc_q) + 1'b1);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i && !busy_o |=> $stable(pc_q));

  assert_skip_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && skip_taken |=> pc_q == $past(pc_q) + 2'd2);

  assert_call_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_RCALL |=> busy_o && mem_we_o && !mem_re_o);

  assert_ret_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_RET |=> busy_o && mem_re_o && !mem_we_o);

  assert_no_wb_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !wb_en_o);

endmodule

// File: tb/flowseq_top_tb_top.sv
`timescale 1ns/1ps
module flowseq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = 16'h0000;
  logic        flag_z_i = 1'b0;
  logic        flag_v_i = 1'b0;
  logic [4:0]  reg_sel_o;
  logic [7:0]  reg_rdata_i;
  logic [15:0] mem_addr_o;
  logic        mem_we_o, mem_re_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic [15:0] pc_o;
  logic        busy_o, wb_en_o;
  logic [4:0]  wb_sel_o;
  logic [7:0]  wb_data_o;

  logic [7:0]  rf [32];
  logic [7:0]  bmem [256];

  int checks = 0;
  int errors = 0;
  logic [15:0] epc, esp;

  always #10 clk = ~clk;

  flowseq_top #(.PC_W(16), .RAM_TOP(16'h08FF)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .flag_z_i(flag_z_i), .flag_v_i(flag_v_i), .reg_sel_o(reg_sel_o),
    .reg_rdata_i(reg_rdata_i), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pc_o(pc_o), .busy_o(busy_o), .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o),
    .wb_data_o(wb_data_o)
  );

  assign reg_rdata_i = rf[reg_sel_o];
  assign mem_rdata_i = bmem[mem_addr_o[7:0]];

  always @(posedge clk) if (mem_we_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Target of a relative transfer: base + signed field + 1, modulo 2^16.
  function automatic logic [15:0] rel(input logic [15:0] p, input int k, input int bits);
    int s;
    s = (k >= (1 << (bits - 1))) ? k - (1 << bits) : k;
    return 16'(int'(p) + s + 1);
  endfunction

  task automatic step_in(input logic [15:0] ins);
    @(negedge clk);
    instr_i = ins;
    instr_valid_i = 1'b1;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid_i = 1'b0;
    #2;
  endtask

  task automatic do_push(input int r);
    step_in(16'h920F | 16'(r << 4));
    chk("R6 sel", reg_sel_o, r);
    chk("R6 we", mem_we_o, 1);
    chk("R6 addr", mem_addr_o, esp);
    chk("R6 data", mem_wdata_o, rf[r]);
    idle();
    esp = esp - 1; epc = epc + 1;
    chk("R2 pc after push", pc_o, epc);
  endtask

  task automatic do_pop(input int r, input logic [7:0] exp);
    step_in(16'h900F | 16'(r << 4));
    chk("R7 re", mem_re_o, 1);
    chk("R7 addr", mem_addr_o, esp + 16'd1);
    chk("R7 wb_en", wb_en_o, 1);
    chk("R7 wb_sel", wb_sel_o, r);
    chk("R7 wb_data", wb_data_o, exp);
    idle();
    esp = esp + 1; epc = epc + 1;
    chk("R2 pc after pop", pc_o, epc);
  endtask

  task automatic do_call(input logic [11:0] k);
    logic [15:0] ret, tgt;
    ret = epc + 1;
    tgt = rel(epc, int'(k), 12);
    step_in({4'hD, k});
    chk("R8 we1", mem_we_o, 1);
    chk("R8 addr1", mem_addr_o, esp);
    chk("R8 lo byte", mem_wdata_o, ret[7:0]);
    chk("R8 busy1", busy_o, 0);
    chk("R11 wb1", wb_en_o, 0);
    @(negedge clk);
    instr_i = {4'hC, 12'h010};  // stray jump while busy
    #2;
    chk("R10 busy", busy_o, 1);
    chk("R8 we2", mem_we_o, 1);
    chk("R8 addr2", mem_addr_o, esp - 16'd1);
    chk("R8 hi byte", mem_wdata_o, ret[15:8]);
    chk("R11 wb2", wb_en_o, 0);
    idle();
    chk("R8 target", pc_o, tgt);
    chk("R10 busy clear", busy_o, 0);
    epc = tgt; esp = esp - 2;
  endtask

  task automatic do_ret(input logic [15:0] exp_ret);
    step_in(16'h9508);
    chk("R9 re1", mem_re_o, 1);
    chk("R9 addr1", mem_addr_o, esp + 16'd1);
    chk("R11 wb1", wb_en_o, 0);
    @(negedge clk);
    instr_i = 16'h920F;  // stray push while busy
    #2;
    chk("R10 busy", busy_o, 1);
    chk("R10 no write", mem_we_o, 0);
    chk("R9 re2", mem_re_o, 1);
    chk("R9 addr2", mem_addr_o, esp + 16'd2);
    chk("R11 wb2", wb_en_o, 0);
    idle();
    chk("R9 return pc", pc_o, exp_ret);
    epc = exp_ret; esp = esp + 2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r1, r2;
    for (int i = 0; i < 32; i++) rf[i] = 8'(i * 29 + 3);
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 pc", pc_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 we", mem_we_o, 0);
    chk("R1 re", mem_re_o, 0);
    chk("R1 wb", wb_en_o, 0);
    rst_n = 1'b1;
    epc = 16'h0000; esp = 16'h08FF;

    // R1: first push lands at the top of data RAM
    do_push(3);

    // R2: idle cycles hold the counter
    repeat (3) begin idle(); chk("R2 hold", pc_o, epc); end

    // R2: undecoded words advance by one
    for (int i = 0; i < 48; i++) begin
      logic [15:0] w;
      w = (i % 3 == 0) ? 16'(i * 37) & 16'h0FFF :
          (i % 3 == 1) ? 16'hE000 | 16'(i * 91) : 16'hA000 | 16'(i * 53);
      step_in(w);
      chk("R11 no wb", wb_en_o, 0);
      idle();
      epc = epc + 1;
      chk("R2 seq", pc_o, epc);
    end

    // R3: relative jump sweep, including wrap below zero
    for (int k = 0; k < 4096; k += 7) begin
      step_in({4'hC, 12'(k)});
      idle();
      epc = rel(epc, k, 12);
      chk("R3 rjmp", pc_o, epc);
    end
    foreach (r1[i]) begin end
    step_in({4'hC, 12'h800}); idle(); epc = rel(epc, 12'h800, 12); chk("R3 min", pc_o, epc);
    step_in({4'hC, 12'h7FF}); idle(); epc = rel(epc, 12'h7FF, 12); chk("R3 max", pc_o, epc);

    // R4: both branches, every offset, both flag values, other flag opposite
    for (int kind = 0; kind < 2; kind++)
      for (int k = 0; k < 128; k++)
        for (int f = 0; f < 2; f++) begin
          if (kind == 0) begin flag_z_i = f[0]; flag_v_i = ~f[0]; end
          else           begin flag_v_i = f[0]; flag_z_i = ~f[0]; end
          step_in(16'hF000 | 16'(k << 3) | (kind == 0 ? 16'h0001 : 16'h0003));
          idle();
          epc = f[0] ? rel(epc, k, 7) : epc + 1;
          chk(kind == 0 ? "R4 breq" : "R4 brvs", pc_o, epc);
        end

    // R5: skips over registers, bits, polarities and bit values
    for (int ri = 0; ri < 4; ri++)
      for (int pol = 0; pol < 2; pol++)
        for (int b = 0; b < 8; b++)
          for (int v = 0; v < 2; v++) begin
            int r;
            logic bitv;
            r = (ri == 0) ? 0 : (ri == 1) ? 5 : (ri == 2) ? 17 : 31;
            rf[r] = v[0] ? 8'h5A : 8'hA5;
            bitv = rf[r][b];
            step_in(16'hFC00 | 16'(pol << 9) | 16'(r << 4) | 16'(b));
            chk("R5 sel", reg_sel_o, r);
            idle();
            epc = epc + (((pol == 1) == bitv) ? 16'd2 : 16'd1);
            chk("R5 skip", pc_o, epc);
          end

    // R6/R7: push two bytes, pop them back in reverse order
    rf[7] = 8'h3C; rf[9] = 8'hC3;
    do_push(7);
    do_push(9);
    do_pop(20, 8'hC3);
    do_pop(21, 8'h7C ^ 8'h40);

    // R8/R9/R10/R11: nested calls, stack use between, returns
    step_in({4'hC, 12'h200}); idle(); epc = rel(epc, 12'h200, 12); chk("R3 pre", pc_o, epc);
    r1 = epc + 1;
    do_call(12'h800);
    r2 = epc + 1;
    do_call(12'h123);
    rf[11] = 8'h96;
    do_push(11);
    do_pop(12, 8'h96);
    do_ret(r2);
    do_ret(r1);
    do_call(12'hFFF);
    r1 = epc - 16'd0;
    do_ret(rel(r1, 12'hFFF, 12) == r1 ? r1 + 1 : r1 + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule